// File: doc/BRIEF.md
# Infrared Edge Interval Timer

This block sits behind the glitch filter of an infrared receiver and measures the time between successive level changes of the filtered signal. Software then decodes any remote-control protocol from the list of intervals. A programmable prescaler divides the core clock into base ticks, and a saturating 13-bit counter counts those ticks. On every edge of the synchronised input the count is captured into the readable interval field and the counter starts again from zero.

With each capture the block stores a flag that says whether the interval that just ended was a mark (carrier present) or a space. An interrupt pulse of one cycle can be raised on rising edges, on falling edges, on both, or on frame events reported by a neighbouring hardware decoder. The enable control starts counting. Pulsing the restart control clears the captured state and the counters. Software normally programs a divider that gives a 10 us tick, for example a divider value of 9 when the tick input runs at 1 MHz.

Top module: `ir_edge_timer`

## Requirements
- R1: After `rst_n` is released, `rd_interval` reads 0, `rd_mark` reads 0 and `irq` is low.
- R2: A base tick occurs once every `cfg_tick_div`+1 clock cycles. When an interval spans N clock cycles between the two captures that bound it, the captured value is floor((N-1)/(`cfg_tick_div`+1)). The prescaler restarts on each capture, and it is held at zero while the block is disabled or restarting.
- R3: The interval counter saturates at 8191 ticks and does not wrap, so a long idle period reads back as 8191.
- R4: Every edge of the synchronised input, rising or falling, captures the count and restarts the counter from zero in the same cycle, whatever the interrupt select value.
- R5: With the default polarity (input high = mark), a falling edge sets `rd_mark` to 1 because a mark has ended, and a rising edge sets `rd_mark` to 0.
- R6: The `cfg_irq_sel` encoding is 1 = both edges, 2 = falling edges only, 3 = rising edges only. `irq` is a one-cycle pulse, and it is visible 3 clock cycles after the input changes: two synchroniser stages and one output register.
- R7: When `cfg_irq_sel` is 0, edges raise no interrupt. A one-cycle `dec_frame_evt` produces a one-cycle `irq` on the following cycle.
- R8: While `ctl_enable` is low, edges capture nothing, `rd_interval` and `rd_mark` hold their values, and `irq` stays low.
- R9: While `ctl_restart` is high, `rd_interval` and `rd_mark` are cleared and `irq` stays low. When `ctl_restart` is released, or when `ctl_enable` rises, the counter starts from zero. The first capture after that point then follows the R2 formula, with N counted from the last cycle in which the block was held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_enable | input | 1 | Starts counting and capturing when high |
| ctl_restart | input | 1 | Synchronous clear of the captured state and the counters |
| cfg_tick_div | input | 12 | Prescaler value; tick period = value+1 clocks |
| cfg_irq_sel | input | 2 | Interrupt source select (see R6, R7) |
| dec_frame_evt | input | 1 | Frame-complete event from a hardware decoder |
| ir_filtered | input | 1 | Filtered receiver input, asynchronous to `clk` |
| rd_interval | output | 13 | Last captured interval in ticks |
| rd_mark | output | 1 | 1 if the captured interval was a mark |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Any change on `ir_filtered` reaches `rd_interval`, `rd_mark` and `irq` at the third rising clock edge after it is driven. The bench drives inputs on falling edges and samples on the third falling edge after the change. It samples `irq` once more one falling edge later to confirm the pulse has ended. A frame event appears on `irq` one edge later, and a restart clears the outputs at the next edge. The expected interval comes from the number of cycles between the two drives that bound it. That count is N, plus 3 cycles when the interval starts at an enable or a restart release.

// File: rtl/ir_timer_pkg.sv
package ir_timer_pkg;

  typedef enum logic [1:0] {
    IRQ_FRAME = 2'd0,
    IRQ_BOTH  = 2'd1,
    IRQ_FALL  = 2'd2,
    IRQ_RISE  = 2'd3
  } irq_sel_e;

  // saturating increment of a counter held in 32 bits
  function automatic logic [31:0] sat_inc(input logic [31:0] cur, input logic [31:0] lim);
    return (cur >= lim) ? lim : cur + 32'd1;
  endfunction

  // whether the selected source fires for this cycle's events
  function automatic logic irq_hit(input irq_sel_e sel, input logic rise,
                                   input logic fall, input logic frame);
    unique case (sel)
      IRQ_FRAME: return frame;
      IRQ_BOTH:  return rise | fall;
      IRQ_FALL:  return fall;
      IRQ_RISE:  return rise;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ir_in_sync.sv
module ir_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[TOP];
  end

  assign level = chain_q[TOP];
  assign rise  = chain_q[TOP] & ~prev_q;
  assign fall  = ~chain_q[TOP] & prev_q;

  // an edge seen now is no longer an edge in the next cycle unless the level flips again
  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && chain_q[TOP]) |=> !(rise && $stable(level))); // R4

endmodule

// File: rtl/ir_tick_prescaler.sv
module ir_tick_prescaler #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] pre_q;
  logic             wrap;

  assign wrap = (pre_q >= div);
  assign tick = run & ~restart & wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pre_q <= '0;
    else if (!run || restart)    pre_q <= '0;
    else if (wrap)               pre_q <= '0;
    else                         pre_q <= pre_q + 1'b1;
  end

  AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (restart || !run) |=> (pre_q == '0)); // R2

endmodule

// File: rtl/ir_interval_counter.sv
module ir_interval_counter
  import ir_timer_pkg::*;
#(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic             tick,
  input  logic             capture,
  output logic [CNT_W-1:0] interval
);
  localparam logic [31:0] CNT_MAX = 32'((64'd1 << CNT_W) - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] interval_q;
  logic [31:0]      cnt_next;

  assign cnt_next = sat_inc(32'(cnt_q), CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      interval_q <= '0;
    end else if (clear) begin
      cnt_q      <= '0;
      interval_q <= '0;
    end else if (!run) begin
      cnt_q      <= '0;
    end else if (capture) begin
      interval_q <= cnt_q;
      cnt_q      <= '0;
    end else if (tick) begin
      cnt_q      <= cnt_next[CNT_W-1:0];
    end
  end

  assign interval = interval_q;

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (cnt_q == '0)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clear && !capture && 32'(cnt_q) == CNT_MAX) |=> (32'(cnt_q) == CNT_MAX)); // R3
  AST_HOLD_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && !clear) |=> $stable(interval_q)); // R8

endmodule

// File: rtl/ir_irq_select.sv
module ir_irq_select
  import ir_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  input  logic       rise,
  input  logic       fall,
  input  logic       frame,
  output logic       irq
);
  irq_sel_e sel_e;
  logic     irq_q;

  assign sel_e = irq_sel_e'(sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= run & irq_hit(sel_e, rise, fall, frame);
  end

  assign irq = irq_q;

  AST_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !irq_q); // R8
  AST_IRQ_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_e == IRQ_RISE && !rise) |=> !irq_q); // R6
  AST_IRQ_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_e == IRQ_FRAME && !frame) |=> !irq_q); // R7

endmodule

// File: rtl/ir_edge_timer.sv
module ir_edge_timer #(
  parameter int CNT_W       = 13,
  parameter int DIV_W       = 12,
  parameter int SYNC_STAGES = 2,
  parameter bit MARK_HIGH   = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_enable,
  input  logic             ctl_restart,
  input  logic [DIV_W-1:0] cfg_tick_div,
  input  logic [1:0]       cfg_irq_sel,
  input  logic             dec_frame_evt,
  input  logic             ir_filtered,
  output logic [CNT_W-1:0] rd_interval,
  output logic             rd_mark,
  output logic             irq
);
  logic in_level;
  logic in_rise;
  logic in_fall;
  logic run;
  logic edge_ok;
  logic tick;
  logic mark_end;
  logic mark_q;

  assign run     = ctl_enable & ~ctl_restart;
  assign edge_ok = run & (in_rise | in_fall);

  generate
    if (MARK_HIGH) begin : g_mark_high
      assign mark_end = in_fall;
    end else begin : g_mark_low
      assign mark_end = in_rise;
    end
  endgenerate

  ir_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (ir_filtered),
    .level (in_level),
    .rise  (in_rise),
    .fall  (in_fall)
  );

  ir_tick_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (edge_ok),
    .div     (cfg_tick_div),
    .tick    (tick)
  );

  ir_interval_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .clear    (ctl_restart),
    .tick     (tick),
    .capture  (edge_ok),
    .interval (rd_interval)
  );

  ir_irq_select u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .sel   (cfg_irq_sel),
    .rise  (in_rise),
    .fall  (in_fall),
    .frame (dec_frame_evt),
    .irq   (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mark_q <= 1'b0;
    else if (ctl_restart) mark_q <= 1'b0;
    else if (edge_ok)     mark_q <= mark_end;
  end

  assign rd_mark = mark_q;

  AST_MARK_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_ok && mark_end) |=> rd_mark); // R5
  AST_SPACE_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_ok && !mark_end) |=> !rd_mark); // R5
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_restart |=> (rd_interval == '0 && !rd_mark && !irq)); // R9
  AST_LEVEL_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(in_level)); // R1

endmodule

// File: tb/test_ir_edge_timer.sv
`timescale 1ns/1ps
module test_ir_edge_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_enable = 1'b0;
  logic        ctl_restart = 1'b0;
  logic [11:0] cfg_tick_div = '0;
  logic [1:0]  cfg_irq_sel = '0;
  logic        dec_frame_evt = 1'b0;
  logic        ir_filtered = 1'b0;
  logic [12:0] rd_interval;
  logic        rd_mark;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ir_edge_timer i_ir_edge_timer (
    .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_restart(ctl_restart),
    .cfg_tick_div(cfg_tick_div), .cfg_irq_sel(cfg_irq_sel),
    .dec_frame_evt(dec_frame_evt), .ir_filtered(ir_filtered),
    .rd_interval(rd_interval), .rd_mark(rd_mark), .irq(irq)
  );

  function automatic int exp_iv(int n, int div);
    int v;
    v = (n - 1) / (div + 1);
    return (v > 8191) ? 8191 : v;
  endfunction

  function automatic bit exp_irq(int sel, bit new_lvl);
    case (sel)
      1: return 1'b1;
      2: return !new_lvl;
      3: return new_lvl;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wait_neg(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // toggle input now (at a falling edge), check outputs 3 cycles later; uses 4 cycles
  task automatic drive_edge(int n_prev, bit check_iv, int div, int sel);
    bit nl;
    nl = !ir_filtered;
    ir_filtered = nl;
    wait_neg(3);
    if (check_iv) chk(rd_interval == 13'(exp_iv(n_prev, div)), "R2/R4 interval",
                      rd_interval, exp_iv(n_prev, div));
    chk(rd_mark == !nl, "R5 mark flag", rd_mark, !nl);
    chk(irq == exp_irq(sel, nl), "R6 irq select", irq, exp_irq(sel, nl));
    wait_neg(1);
    chk(irq == 1'b0, "R6 one-cycle irq", irq, 0);
  endtask

  task automatic start_block(int div, int sel);
    ctl_enable = 1'b0;
    cfg_tick_div = 12'(div);
    cfg_irq_sel = 2'(sel);
    wait_neg(1);
    ctl_enable = 1'b1;
  endtask

  task automatic run_block(int div, int sel, int edges);
    int g;
    start_block(div, sel);
    g = 5 + int'($urandom % 30);
    wait_neg(g);
    drive_edge(g + 3, 1'b1, div, sel);
    for (int e = 0; e < edges; e++) begin
      g = 5 + int'($urandom % (20 * (div + 1)));
      wait_neg(g - 4);
      drive_edge(g, 1'b1, div, sel);
    end
  endtask

  initial begin
    int held_iv;
    bit held_mk;
    void'($urandom(32'd2024));
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(1);
    chk(rd_interval == 13'd0, "R1 reset interval", rd_interval, 0);
    chk(rd_mark == 1'b0, "R1 reset mark", rd_mark, 0);
    chk(irq == 1'b0, "R1 reset irq", irq, 0);

    // directed: divider 9, both edges
    start_block(9, 1);
    wait_neg(20);
    drive_edge(23, 1'b1, 9, 1);
    wait_neg(41 - 4);
    drive_edge(41, 1'b1, 9, 1);
    wait_neg(10 - 4);
    drive_edge(10, 1'b1, 9, 1);

    // R3 saturation with divider 0
    start_block(0, 2);
    wait_neg(8);
    drive_edge(11, 1'b1, 0, 2);
    wait_neg(8191 - 4);
    drive_edge(8191, 1'b1, 0, 2);
    wait_neg(8192 - 4);
    drive_edge(8192, 1'b1, 0, 2);
    wait_neg(9000 - 4);
    drive_edge(9000, 1'b1, 0, 2);
    chk(rd_interval == 13'd8191, "R3 saturate", rd_interval, 8191);

    // random blocks
    for (int b = 0; b < 8; b++)
      run_block(int'($urandom % 8), int'($urandom % 4), 6);

    // R7 frame event source
    start_block(3, 0);
    wait_neg(6);
    drive_edge(9, 1'b1, 3, 0);
    dec_frame_evt = 1'b1;
    wait_neg(1);
    dec_frame_evt = 1'b0;
    chk(irq == 1'b1, "R7 frame irq", irq, 1);
    wait_neg(1);
    chk(irq == 1'b0, "R7 frame irq ends", irq, 0);
    cfg_irq_sel = 2'd1;
    dec_frame_evt = 1'b1;
    wait_neg(1);
    dec_frame_evt = 1'b0;
    chk(irq == 1'b0, "R7 frame ignored when sel=1", irq, 0);

    // R8 disabled: edges ignored
    wait_neg(5);
    held_iv = rd_interval;
    held_mk = rd_mark;
    ctl_enable = 1'b0;
    wait_neg(1);
    ir_filtered = !ir_filtered;
    wait_neg(3);
    chk(irq == 1'b0, "R8 no irq when disabled", irq, 0);
    chk(rd_interval == 13'(held_iv), "R8 interval held", rd_interval, held_iv);
    chk(rd_mark == held_mk, "R8 mark held", rd_mark, held_mk);
    wait_neg(3);

    // R9 restart clears and counting starts from zero after release
    ctl_enable = 1'b1;
    cfg_tick_div = 12'd1;
    cfg_irq_sel = 2'd3;
    wait_neg(12);
    drive_edge(15, 1'b1, 1, 3);
    wait_neg(4);
    ctl_restart = 1'b1;
    wait_neg(2);
    chk(rd_interval == 13'd0, "R9 restart interval", rd_interval, 0);
    chk(rd_mark == 1'b0, "R9 restart mark", rd_mark, 0);
    chk(irq == 1'b0, "R9 restart irq", irq, 0);
    ctl_restart = 1'b0;
    wait_neg(17);
    drive_edge(20, 1'b1, 1, 3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule